// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Generator

This block produces symmetric (center-aligned) pulse width modulation for three half-bridge phases. A shared counter climbs from 1 to a programmable top value and then falls back to 1, over and over, which forms a triangular carrier. The top value sets the carrier period. Each phase compares the counter with its own compare value. That gives a raw level whose width is set by the compare value. The raw level is then split into a high-side and a low-side gate. A programmable number of clocks is inserted between the two, so that the two switches of one leg are never driven together.

New compare values are held off until the counter reaches its top. At that edge the block copies them into the active compare registers and raises a one-cycle period interrupt. Software therefore has a full carrier period to supply the next set of values. Each of the six gate pins has its own polarity bit and its own force-high and force-low controls. The force controls act on the pin directly.

The timebase sequencer has two states: `CNT_UP` and `CNT_DOWN`. `CNT_UP` moves to `CNT_DOWN` when the counter is at or above the top value. `CNT_DOWN` moves to `CNT_UP` when the counter reaches 1. Each phase has a gate sequencer with four states: `DB_LOW` (low side on), `DB_WAIT_HI` (both off, heading high), `DB_HIGH` (high side on) and `DB_WAIT_LO` (both off, heading low). A rising raw level moves `DB_LOW` or `DB_WAIT_LO` to `DB_WAIT_HI`, or to `DB_HIGH` directly when the dead time is 0. A falling raw level moves `DB_HIGH` or `DB_WAIT_HI` to `DB_WAIT_LO`, or to `DB_LOW` directly when the dead time is 0. When the dead-time count runs out, `DB_WAIT_HI` moves to `DB_HIGH` and `DB_WAIT_LO` moves to `DB_LOW`.

Top module: `cpwm_gen`

## Requirements
- R1: The counter starts at 1 counting up and steps by one each enabled cycle between 1 and top, where top is `rld_i`, or 2 when `rld_i` is below 2. One carrier period is therefore 2*(top-1) cycles.
- R2: `irq_o` is high for exactly one cycle, the cycle after the counter sat at or above top while counting up.
- R3: A channel's active compare value is loaded from its field of `cmp_i` only on the edge that raises `irq_o`. Changes to `cmp_i` at any other time have no effect on the gates until then. Channel c uses bits 8c+7:8c, and the active value is 0 after reset.
- R4: A channel's raw level is active in the cycle after the counter is below its active compare value. A compare value of 0 or 1 therefore gives a constant inactive level, a value above top gives a constant active level, and a value equal to top drops the level only around the peak, with no single-cycle glitch elsewhere.
- R5: The high-side gate (bit 2c) follows the raw level and the low-side gate (bit 2c+1) follows its inverse, one cycle later. After every raw edge both gates stay inactive for exactly `dt_i` cycles. With `dt_i`=0 there is no gap.
- R6: A raw pulse lasting at most `dt_i` cycles never turns on the gate it would have delayed.
- R7: While `en_i` is low the counter holds, `irq_o` stays low and every raw level is inactive, so every pair settles on its low side.
- R8: `frc_hi_i[i]` drives pin i high and `frc_lo_i[i]` drives it low, whatever the gate state and polarity. Force-high wins when both are set.
- R9: `pol_i[i]`=1 inverts pin i after dead-time insertion, so the inactive level of the pin equals its polarity bit.
- R10: During and right after reset every unforced pin sits at its inactive level (equal to `pol_i`) and `irq_o` is low.
- R11: The two gates of a pair are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Counter run enable |
| rld_i | input | 8 | Carrier top value |
| cmp_i | input | 24 | Pending compare values, channel c in bits 8c+7:8c |
| dt_i | input | 8 | Dead time in clock cycles |
| pol_i | input | 6 | Per-pin polarity (1 = active low) |
| frc_hi_i | input | 6 | Per-pin force high |
| frc_lo_i | input | 6 | Per-pin force low |
| gate_o | output | 6 | Gate pins, 2c high side and 2c+1 low side of channel c |
| irq_o | output | 1 | Period interrupt at carrier peak |

## Verification
`irq_o` rises one cycle after the counter is at its peak, and the new compare values are in effect from that same edge. A counter value reaches the raw level one cycle later and the gate pins one more cycle later, plus `dt_i` cycles whenever a dead gap applies. Polarity and force act on the pins in the same cycle. The bench keeps a cycle model built from these latencies and updates it on the rising edge. Inputs are driven and every output is compared on the falling edge, so each result is checked exactly in the cycle it is due. Directed phases cover the compare corner values, short-pulse suppression, disable, force and polarity. Seeded random stretches cover the rest.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic {CNT_UP, CNT_DOWN} cnt_dir_t;
    typedef enum logic [1:0] {DB_LOW, DB_WAIT_HI, DB_HIGH, DB_WAIT_LO} db_state_t;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [CW-1:0] rld_i,
    output logic [CW-1:0] cnt_o,
    output logic          peak_o,
    output logic          irq_o
);
    import cpwm_pkg::*;
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    cnt_dir_t      dir_q, dir_d;
    logic [CW-1:0] cnt_q, cnt_d, top;

    assign top    = (rld_i < TWO) ? TWO : rld_i;
    assign peak_o = en_i && (dir_q == CNT_UP) && (cnt_q >= top);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= CNT_UP;
            cnt_q <= ONE;
            irq_o <= 1'b0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
            irq_o <= peak_o;
        end
    end

    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        if (en_i) begin
            unique case (dir_q)
                CNT_UP: begin
                    if (cnt_q >= top) begin
                        dir_d = CNT_DOWN;
                        cnt_d = cnt_q - ONE;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                CNT_DOWN: begin
                    if (cnt_q <= ONE) begin
                        dir_d = CNT_UP;
                        cnt_d = cnt_q + ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        en_i |=> (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE));
    // R1
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst) cnt_q != '0);
    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst) !en_i |=> $stable(cnt_q));
    // R2
    irq_single_chk: assert property (@(posedge clk) disable iff (rst) irq_o |=> !irq_o);
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          load_i,
    input  logic [CW-1:0] cmp_i,
    output logic          raw_o
);
    logic [CW-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            raw_o <= 1'b0;
        end else begin
            if (load_i) act_q <= cmp_i;
            raw_o <= en_i && (cnt_i < act_q);
        end
    end

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (rst) !load_i |=> $stable(act_q));
    // R4
    raw_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q == '0) && $stable(act_q) |=> !raw_o);
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raw_i,
    input  logic [DW-1:0] dt_i,
    output logic          hi_o,
    output logic          lo_o
);
    import cpwm_pkg::*;

    db_state_t     st_q, st_d;
    logic [DW-1:0] dc_q, dc_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= DB_WAIT_LO;
            dc_q <= '0;
        end else begin
            st_q <= st_d;
            dc_q <= dc_d;
        end
    end

    always_comb begin
        st_d = st_q;
        dc_d = dc_q;
        unique case (st_q)
            DB_LOW, DB_WAIT_LO: begin
                if (raw_i) begin
                    st_d = (dt_i == '0) ? DB_HIGH : DB_WAIT_HI;
                    dc_d = dt_i - 1'b1;
                end else if (st_q == DB_WAIT_LO) begin
                    if (dc_q == '0) st_d = DB_LOW;
                    else            dc_d = dc_q - 1'b1;
                end
            end
            DB_HIGH, DB_WAIT_HI: begin
                if (!raw_i) begin
                    st_d = (dt_i == '0) ? DB_LOW : DB_WAIT_LO;
                    dc_d = dt_i - 1'b1;
                end else if (st_q == DB_WAIT_HI) begin
                    if (dc_q == '0) st_d = DB_HIGH;
                    else            dc_d = dc_q - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        hi_o = (st_q == DB_HIGH);
        lo_o = (st_q == DB_LOW);
    end

    // R5
    hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_o) |-> (!$past(lo_o) || ($past(dt_i) == '0)));
    // R5
    lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_o) |-> (!$past(hi_o) || ($past(dt_i) == '0)));
    // R6
    short_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_o) |-> $past(raw_i));
endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen #(
    parameter int CW  = 8,
    parameter int DW  = 8,
    parameter int NCH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [CW-1:0]     rld_i,
    input  logic [NCH*CW-1:0] cmp_i,
    input  logic [DW-1:0]     dt_i,
    input  logic [2*NCH-1:0]  pol_i,
    input  logic [2*NCH-1:0]  frc_hi_i,
    input  logic [2*NCH-1:0]  frc_lo_i,
    output logic [2*NCH-1:0]  gate_o,
    output logic              irq_o
);
    localparam int NG = 2 * NCH;

    logic [CW-1:0] cnt;
    logic          peak;
    logic [NG-1:0] gate_act;

    cpwm_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst(rst), .en_i(en_i), .rld_i(rld_i),
        .cnt_o(cnt), .peak_o(peak), .irq_o(irq_o)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic raw;
        cpwm_compare #(.CW(CW)) u_cmp (
            .clk(clk), .rst(rst), .en_i(en_i), .cnt_i(cnt),
            .load_i(peak), .cmp_i(cmp_i[c*CW +: CW]), .raw_o(raw)
        );
        cpwm_deadband #(.DW(DW)) u_db (
            .clk(clk), .rst(rst), .raw_i(raw), .dt_i(dt_i),
            .hi_o(gate_act[2*c]), .lo_o(gate_act[2*c+1])
        );
        // R11
        pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
            !(gate_act[2*c] && gate_act[2*c+1]));
    end

    for (genvar i = 0; i < NG; i++) begin : g_pin
        always_comb begin
            if (frc_hi_i[i])      gate_o[i] = 1'b1;
            else if (frc_lo_i[i]) gate_o[i] = 1'b0;
            else                  gate_o[i] = gate_act[i] ^ pol_i[i];
        end
    end
endmodule

// File: tb/cpwm_gen_test.sv
module cpwm_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [7:0]  rld = 8'd6;
    logic [23:0] cmp = '0;
    logic [7:0]  dt = '0;
    logic [5:0]  pol = 6'b100100;
    logic [5:0]  fh = '0;
    logic [5:0]  fl = '0;
    logic [5:0]  gate;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_req = "R10";

    cpwm_gen uut (
        .clk(clk), .rst(rst), .en_i(en), .rld_i(rld), .cmp_i(cmp), .dt_i(dt),
        .pol_i(pol), .frc_hi_i(fh), .frc_lo_i(fl), .gate_o(gate), .irq_o(irq)
    );

    always #4 clk = ~clk;

    // reference model: states 0 low, 1 wait-high, 2 high, 3 wait-low
    logic [7:0] m_cnt, m_top;
    logic       m_up, m_irq, m_pk;
    logic [7:0] m_act [3];
    logic       m_raw [3];
    logic [1:0] m_st  [3];
    logic [7:0] m_dc  [3];

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = 8'd1; m_up = 1'b1; m_irq = 1'b0;
            for (int c = 0; c < 3; c++) begin
                m_act[c] = '0; m_raw[c] = 1'b0; m_st[c] = 2'd3; m_dc[c] = '0;
            end
        end else begin
            m_top = (rld < 8'd2) ? 8'd2 : rld;
            m_pk  = en && m_up && (m_cnt >= m_top);
            for (int c = 0; c < 3; c++) begin
                if ((m_st[c] == 2'd0 || m_st[c] == 2'd3) && m_raw[c]) begin
                    m_st[c] = (dt == 0) ? 2'd2 : 2'd1; m_dc[c] = dt - 8'd1;
                end else if ((m_st[c] == 2'd2 || m_st[c] == 2'd1) && !m_raw[c]) begin
                    m_st[c] = (dt == 0) ? 2'd0 : 2'd3; m_dc[c] = dt - 8'd1;
                end else if (m_st[c] == 2'd1 || m_st[c] == 2'd3) begin
                    if (m_dc[c] == 0) m_st[c] = (m_st[c] == 2'd1) ? 2'd2 : 2'd0;
                    else              m_dc[c] = m_dc[c] - 8'd1;
                end
                m_raw[c] = en && (m_cnt < m_act[c]);
                if (m_pk) m_act[c] = cmp[c*8 +: 8];
            end
            if (en) begin
                if (m_up) begin
                    if (m_cnt >= m_top) begin m_up = 1'b0; m_cnt = m_cnt - 8'd1; end
                    else m_cnt = m_cnt + 8'd1;
                end else begin
                    if (m_cnt <= 8'd1) begin m_up = 1'b1; m_cnt = m_cnt + 8'd1; end
                    else m_cnt = m_cnt - 8'd1;
                end
            end
            m_irq = m_pk;
        end
    end

    function automatic logic [5:0] exp_pins();
        logic [5:0] g;
        for (int c = 0; c < 3; c++) begin
            g[2*c]   = (m_st[c] == 2'd2);
            g[2*c+1] = (m_st[c] == 2'd0);
        end
        for (int i = 0; i < 6; i++)
            g[i] = fh[i] ? 1'b1 : (fl[i] ? 1'b0 : g[i] ^ pol[i]);
        return g;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d got %0h expected %0h", req, cyc, got, exp);
        end
    endtask

    task automatic step();
        logic [5:0] lg;
        @(negedge clk);
        chk(cur_req, {26'd0, irq, gate}, {26'd0, m_irq, exp_pins()});
        if (fh == 0 && fl == 0) begin
            lg = gate ^ pol;
            for (int c = 0; c < 3; c++)
                chk("R11", {31'd0, lg[2*c] & lg[2*c+1]}, 32'd0);
        end
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R10: reset state, pins at inactive level
        repeat (3) begin
            @(negedge clk);
            chk("R10", {26'd0, irq, gate}, {27'd0, pol});
        end
        rst = 1'b0;
        pol = '0;
        run(2);
        chk("R10", {26'd0, gate}, 32'b101010);
        // R1 / R2: basic carrier, compare loaded at first peak
        en = 1'b1; rld = 8'd6; cmp = {8'd4, 8'd3, 8'd2}; dt = 8'd1;
        cur_req = "R1"; run(40);
        cur_req = "R2"; rld = 8'd1; run(20);
        rld = 8'd9; run(40);
        // R3: compare changes mid-period only take effect at the peak
        cur_req = "R3";
        for (int k = 0; k < 12; k++) begin
            cmp = {8'($urandom_range(0, 10)), 8'($urandom_range(0, 10)), 8'($urandom_range(0, 10))};
            run($urandom_range(1, 9));
        end
        // R4: compare corner values
        cur_req = "R4"; dt = 8'd0;
        cmp = {8'd10, 8'd1, 8'd0}; run(50);
        cmp = {8'd255, 8'd9, 8'd9}; run(50);
        // R5: dead time 0 and wider gaps
        cur_req = "R5"; cmp = {8'd6, 8'd5, 8'd3};
        dt = 8'd0; run(40);
        dt = 8'd3; run(60);
        // R6: narrow pulses vs dead time 3 (lengths 1 and 3 suppressed, 5 passes)
        cur_req = "R6"; rld = 8'd10; cmp = {8'd4, 8'd3, 8'd2}; run(25);
        for (int k = 0; k < 40; k++) begin
            step();
            chk("R6", {30'd0, gate[2], gate[0]}, 32'd0);
        end
        // R7: disable
        cur_req = "R7"; en = 1'b0; run(25);
        chk("R7", {26'd0, irq, gate}, 32'b101010);
        en = 1'b1; run(10);
        // R8: force overrides, force-high wins
        cur_req = "R8"; fh = 6'b000011; fl = 6'b000110; pol = 6'b111111; run(15);
        chk("R8", {26'd0, gate[2:0]}, 32'b011);
        fh = '0; fl = '0;
        // R9: polarity inversion
        cur_req = "R9"; pol = 6'b010101; run(40);
        pol = 6'b101010; run(20);
        // random mix
        cur_req = "R5";
        for (int k = 0; k < 300; k++) begin
            rld = 8'($urandom_range(2, 30));
            cmp = {8'($urandom_range(0, 32)), 8'($urandom_range(0, 32)), 8'($urandom_range(0, 32))};
            dt  = 8'($urandom_range(0, 6));
            pol = 6'($urandom);
            en  = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 7) == 0) begin fh = 6'($urandom); fl = 6'($urandom); end
            else begin fh = '0; fl = '0; end
            run($urandom_range(1, 20));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule